// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block is the control engine of a single-channel DMA controller. Software writes the address of a first descriptor and then issues commands through a small register write port. The sequencer reads each descriptor as three 64-bit words over a memory read port and hands the addresses, attributes and byte count to a separate transfer engine. It then waits for that engine to report completion or an error, and it either follows the chain to the next descriptor or stops.

A descriptor whose link field is zero describes a single transfer (direct mode). Otherwise the link field gives the next 32-byte-aligned descriptor, and its least significant bit marks the final one. Software can pause, resume and abort an operation in flight. An 8-bit status register and a gated interrupt report how each operation ended.

Top module: `dma_chain_seq`

## Requirements
- R1: A descriptor at address A is read from A, A+8 and A+16. Word A holds the source address in bits 63:32 and the source attributes in bits 31:0. Word A+8 holds the destination address and destination attributes in the same way. Word A+16 holds the link field in bits 63:32 and the byte count in bits 31:0. These fields appear unchanged on the xfer_* outputs when xfer_start_o pulses.
- R2: A link field equal to zero gives exactly one transfer and no further memory read, and the operation ends with the done flag set. The memory port has at most one read outstanding, and mem_req_o is never high on two consecutive cycles.
- R3: A nonzero link field whose bit 0 is clear chains to the descriptor at {link[31:5], 5'b0}, so link bits 4:1 are ignored. When bit 0 is set, the chain ends with done after that descriptor's transfer.
- R4: The status bits are, from status_o[7] down to status_o[0]: master abort, target abort, retry limit, bus time-out, abort, pause, done, busy. Busy is 1 from an accepted start until done, abort or error. Done and busy are never both set.
- R5: A start command while busy is ignored. The running operation continues, and no new descriptor is fetched.
- R6: A pause while busy sets the pause flag and holds xfer_hold_o high. While paused, no memory read and no transfer start is issued. Resume continues from the same point, and every transfer of the chain occurs exactly once, in order.
- R7: An abort while busy clears busy, sets the abort flag and pulses xfer_kill_o for one cycle on the following cycle.
- R8: A nonzero xfer_err_i while a transfer is outstanding stops the chain at once. Its bits [3:0] (master abort, target abort, retry limit, time-out) are ORed into status_o[7:4].
- R9: Done, abort or error sets an interrupt-pending bit. irq_o = pending & enable & ~mask. Writing a 1 in bit 0 to the clear register clears pending.
- R10: Flags other than busy stay set until the next accepted start, which clears them in the same cycle that busy rises.
- R11: Register map by reg_addr_i: 0 = descriptor pointer, 1 = command (bit 0 start, bit 1 pause, bit 2 resume, bit 3 abort; abort wins), 2 = interrupt enable (bit 0), 3 = interrupt mask (bit 0), 4 = interrupt clear (bit 0). All are reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| xfer_start_o | output | 1 | Transfer start pulse |
| xfer_src_o | output | 32 | Source address |
| xfer_src_attr_o | output | 32 | Source attributes |
| xfer_dst_o | output | 32 | Destination address |
| xfer_dst_attr_o | output | 32 | Destination attributes |
| xfer_cnt_o | output | 32 | Byte count |
| xfer_hold_o | output | 1 | Engine freeze while paused |
| xfer_kill_o | output | 1 | Engine abort pulse |
| xfer_done_i | input | 1 | Transfer completed |
| xfer_err_i | input | 4 | Transfer error causes |
| status_o | output | 8 | Status flags |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong word index or base pointer appears within a few cycles as a read outside the prepared descriptors, or as transfer fields that disagree with the scoreboard at the next xfer_start_o. A pause flag that fails to gate issue states shows as a memory read or a transfer start during the held window. A bad chain-end decode shows as a missing or extra transfer before busy falls. Sticky-flag and interrupt-pending errors show as a status or irq_o mismatch on the cycle right after the ending event or the register write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int DESC_WORDS = 3;
  localparam int LINK_LSB   = 5;
  localparam int ERR_W      = 4;

  localparam logic [2:0] REG_PTR  = 3'd0;
  localparam logic [2:0] REG_CMD  = 3'd1;
  localparam logic [2:0] REG_IEN  = 3'd2;
  localparam logic [2:0] REG_IMSK = 3'd3;
  localparam logic [2:0] REG_ICLR = 3'd4;

  localparam int CMD_START  = 0;
  localparam int CMD_PAUSE  = 1;
  localparam int CMD_RESUME = 2;
  localparam int CMD_ABORT  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_XF_GO, S_XF_WAIT
  } seq_state_e;
endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm import dma_seq_pkg::*; #(
  parameter int WW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pause_i,
  input  logic              resume_i,
  input  logic              abort_i,
  input  logic [WW/2-1:0]   ptr_i,
  output logic              mem_req_o,
  output logic [WW/2-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WW-1:0]     mem_rdata_i,
  output logic              xfer_start_o,
  output logic [WW/2-1:0]   src_o,
  output logic [WW/2-1:0]   src_attr_o,
  output logic [WW/2-1:0]   dst_o,
  output logic [WW/2-1:0]   dst_attr_o,
  output logic [WW/2-1:0]   cnt_o,
  output logic              xfer_hold_o,
  output logic              xfer_kill_o,
  input  logic              xfer_done_i,
  input  logic [ERR_W-1:0]  xfer_err_i,
  output logic              busy_o,
  output logic              start_go_o,
  output logic              pause_go_o,
  output logic              abort_go_o,
  output logic              done_ev_o,
  output logic [ERR_W-1:0]  err_ev_o
);
  localparam int FW    = WW / 2;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int STEP  = $clog2(WW / 8);

  seq_state_e             state_q;
  logic [IDX_W-1:0]       idx_q;
  logic [FW-1:0]          base_q;
  logic                   paused_q, kill_q;
  logic [WW-1:0]          word_q [DESC_WORDS];
  logic [FW-1:0]          link;
  logic                   busy, start_go, abort_go, pause_go, resume_go;
  logic                   in_wait, err_hit, done_hit, chain_end, finish;

  assign busy      = (state_q != S_IDLE);
  assign start_go  = start_i & ~busy & ~abort_i;
  assign abort_go  = abort_i & busy;
  assign pause_go  = pause_i & busy & ~paused_q & ~abort_i;
  assign resume_go = resume_i & paused_q & ~abort_i & ~pause_i;

  assign link      = word_q[DESC_WORDS-1][WW-1:FW];
  assign chain_end = (link == '0) | link[0];
  assign in_wait   = (state_q == S_XF_WAIT);
  assign err_hit   = in_wait & (|xfer_err_i);
  assign done_hit  = in_wait & ~(|xfer_err_i) & xfer_done_i;
  assign finish    = err_hit | (done_hit & chain_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
    end else if (abort_go) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_go) begin
          base_q  <= ptr_i;
          idx_q   <= '0;
          state_q <= S_RD_REQ;
        end
        S_RD_REQ: if (!paused_q) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid_i) begin
          if (idx_q == IDX_W'(DESC_WORDS - 1)) state_q <= S_XF_GO;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RD_REQ;
          end
        end
        S_XF_GO: if (!paused_q) state_q <= S_XF_WAIT;
        S_XF_WAIT: begin
          if (finish) state_q <= S_IDLE;
          else if (done_hit) begin
            base_q  <= {link[FW-1:LINK_LSB], LINK_LSB'(0)};
            idx_q   <= '0;
            state_q <= S_RD_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DESC_WORDS; i++) word_q[i] <= '0;
    end else if (state_q == S_RD_WAIT && mem_rvalid_i) begin
      for (int i = 0; i < DESC_WORDS; i++)
        if (idx_q == IDX_W'(i)) word_q[i] <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q <= 1'b0;
      kill_q   <= 1'b0;
    end else begin
      kill_q <= abort_go;
      if (abort_go || start_go || finish) paused_q <= 1'b0;
      else if (pause_go)                  paused_q <= 1'b1;
      else if (resume_go)                 paused_q <= 1'b0;
    end
  end

  assign mem_req_o    = (state_q == S_RD_REQ) & ~paused_q;
  assign mem_addr_o   = base_q + (FW'(idx_q) << STEP);
  assign xfer_start_o = (state_q == S_XF_GO) & ~paused_q;
  assign src_o        = word_q[0][WW-1:FW];
  assign src_attr_o   = word_q[0][FW-1:0];
  assign dst_o        = word_q[1][WW-1:FW];
  assign dst_attr_o   = word_q[1][FW-1:0];
  assign cnt_o        = word_q[2][FW-1:0];
  assign xfer_hold_o  = paused_q;
  assign xfer_kill_o  = kill_q;
  assign busy_o       = busy;
  assign start_go_o   = start_go;
  assign pause_go_o   = pause_go;
  assign abort_go_o   = abort_go;
  assign done_ev_o    = done_hit & chain_end;
  assign err_ev_o     = in_wait ? xfer_err_i : '0;
endmodule

// File: rtl/dma_seq_stat.sv
module dma_seq_stat import dma_seq_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic             pause_i,
  input  logic             abort_i,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             ien_we_i,
  input  logic             imsk_we_i,
  input  logic             iclr_we_i,
  input  logic             bit_i,
  output logic [ERR_W+3:0] status_o,
  output logic             irq_o
);
  logic [ERR_W+2:0] flags_q;
  logic             ien_q, imsk_q, pend_q, end_ev;

  assign end_ev = done_i | abort_i | (|err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ien_q   <= 1'b0;
      imsk_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (start_i) flags_q <= '0;
      else         flags_q <= flags_q | {err_i, abort_i, pause_i, done_i};
      if (ien_we_i)  ien_q  <= bit_i;
      if (imsk_we_i) imsk_q <= bit_i;
      if (end_ev)                  pend_q <= 1'b1;
      else if (iclr_we_i && bit_i) pend_q <= 1'b0;
    end
  end

  assign status_o = {flags_q, busy_i};
  assign irq_o    = pend_q & ien_q & ~imsk_q;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq import dma_seq_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [63:0] mem_rdata_i,
  output logic        xfer_start_o,
  output logic [31:0] xfer_src_o,
  output logic [31:0] xfer_src_attr_o,
  output logic [31:0] xfer_dst_o,
  output logic [31:0] xfer_dst_attr_o,
  output logic [31:0] xfer_cnt_o,
  output logic        xfer_hold_o,
  output logic        xfer_kill_o,
  input  logic        xfer_done_i,
  input  logic [3:0]  xfer_err_i,
  output logic [7:0]  status_o,
  output logic        irq_o
);
  logic [31:0]      ptr_q;
  logic             cmd_we;
  logic             busy, start_go, pause_go, abort_go, done_ev;
  logic [ERR_W-1:0] err_ev;

  assign cmd_we = reg_we_i && (reg_addr_i == REG_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (reg_we_i && reg_addr_i == REG_PTR) ptr_q <= reg_wdata_i;
  end

  dma_seq_fsm #(.WW(64)) u_fsm (
    .clk_i, .rst_ni,
    .start_i     (cmd_we & reg_wdata_i[CMD_START]),
    .pause_i     (cmd_we & reg_wdata_i[CMD_PAUSE]),
    .resume_i    (cmd_we & reg_wdata_i[CMD_RESUME]),
    .abort_i     (cmd_we & reg_wdata_i[CMD_ABORT]),
    .ptr_i       (ptr_q),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .xfer_start_o,
    .src_o       (xfer_src_o),
    .src_attr_o  (xfer_src_attr_o),
    .dst_o       (xfer_dst_o),
    .dst_attr_o  (xfer_dst_attr_o),
    .cnt_o       (xfer_cnt_o),
    .xfer_hold_o, .xfer_kill_o, .xfer_done_i, .xfer_err_i,
    .busy_o      (busy),
    .start_go_o  (start_go),
    .pause_go_o  (pause_go),
    .abort_go_o  (abort_go),
    .done_ev_o   (done_ev),
    .err_ev_o    (err_ev)
  );

  dma_seq_stat u_stat (
    .clk_i, .rst_ni,
    .busy_i    (busy),
    .start_i   (start_go),
    .pause_i   (pause_go),
    .abort_i   (abort_go),
    .done_i    (done_ev),
    .err_i     (err_ev),
    .ien_we_i  (reg_we_i && reg_addr_i == REG_IEN),
    .imsk_we_i (reg_we_i && reg_addr_i == REG_IMSK),
    .iclr_we_i (reg_we_i && reg_addr_i == REG_ICLR),
    .bit_i     (reg_wdata_i[0]),
    .status_o,
    .irq_o
  );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        mem_req_o,
  input logic        xfer_start_o,
  input logic        xfer_hold_o,
  input logic        xfer_kill_o,
  input logic        xfer_done_i,
  input logic [3:0]  xfer_err_i,
  input logic [7:0]  status_o
);
  logic start_only;
  assign start_only = reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[3:0] == 4'b0001;

  a_r2_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r4_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[1] && status_o[0]));

  a_r1_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> status_o[0]);

  a_r6_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_hold_o |-> (!mem_req_o && !xfer_start_o && status_o[2] && status_o[0]));

  a_r7_kill_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_kill_o |-> (!status_o[0] && status_o[3]));

  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && start_only && !xfer_done_i && xfer_err_i == 4'd0) |=> status_o[0]);
endmodule

bind dma_chain_seq dma_chain_seq_chk u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .mem_req_o,
  .xfer_start_o, .xfer_hold_o, .xfer_kill_o, .xfer_done_i, .xfer_err_i, .status_o
);

// File: tb/dma_chain_seq_test.sv
`timescale 1ns/1ps
module dma_chain_seq_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_rdata_i = '0;
  logic        xfer_start_o, xfer_hold_o, xfer_kill_o, xfer_done_i = 1'b0;
  logic [31:0] xfer_src_o, xfer_src_attr_o, xfer_dst_o, xfer_dst_attr_o, xfer_cnt_o;
  logic [3:0]  xfer_err_i = '0;
  logic [7:0]  status_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  dma_chain_seq uut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .xfer_start_o, .xfer_src_o, .xfer_src_attr_o, .xfer_dst_o, .xfer_dst_attr_o,
    .xfer_cnt_o, .xfer_hold_o, .xfer_kill_o, .xfer_done_i, .xfer_err_i,
    .status_o, .irq_o
  );

  typedef struct { logic [31:0] s, sa, d, da, c; } xf_t;
  xf_t         exp_q[$];
  logic [63:0] mem [logic [31:0]];
  int total = 0, bad = 0;
  int req_cnt = 0, xs_cnt = 0, kill_cnt = 0, bad_addr = 0;
  int eng_delay = 4, eng_cnt = 0;
  logic [3:0] err_inject = '0;
  bit eng_busy = 0, pend = 0, ended = 0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, s, sa, d, da, link, c, input bit expect_it);
    mem[a]      = {s, sa};
    mem[a + 8]  = {d, da};
    mem[a + 16] = {link, c};
    if (expect_it) exp_q.push_back('{s, sa, d, da, c});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && status_o[0]; i++) @(negedge clk);
  endtask

  task automatic wait_xs(input int n);
    for (int i = 0; i < 2000 && xs_cnt < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // memory, engine and scoreboard monitor
  initial forever begin
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    xfer_done_i  = 1'b0;
    xfer_err_i   = '0;
    if (pend) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mem.exists(pend_addr) ? mem[pend_addr] : 64'hdead_beef_dead_beef;
      pend = 0;
    end
    if (mem_req_o) begin
      req_cnt++;
      if (!mem.exists(mem_addr_o)) bad_addr++;
      pend = 1; pend_addr = mem_addr_o;
    end
    if (xfer_kill_o) begin kill_cnt++; eng_busy = 0; end
    if (eng_busy) begin
      if (!xfer_hold_o) eng_cnt--;
      if (eng_cnt <= 0) begin
        if (err_inject != 0) begin xfer_err_i = err_inject; err_inject = '0; end
        else xfer_done_i = 1'b1;
        eng_busy = 0;
      end
    end
    if (xfer_start_o) begin
      xs_cnt++;
      if (exp_q.size() == 0) chk(0, "R1 unexpected transfer", xfer_src_o, 0);
      else begin
        xf_t e;
        e = exp_q.pop_front();
        chk(xfer_src_o == e.s,       "R1 src",      xfer_src_o, e.s);
        chk(xfer_src_attr_o == e.sa, "R1 src_attr", xfer_src_attr_o, e.sa);
        chk(xfer_dst_o == e.d,       "R1 dst",      xfer_dst_o, e.d);
        chk(xfer_dst_attr_o == e.da, "R1 dst_attr", xfer_dst_attr_o, e.da);
        chk(xfer_cnt_o == e.c,       "R1 cnt",      xfer_cnt_o, e.c);
      end
      eng_busy = 1; eng_cnt = eng_delay;
    end
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int r0, x0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R4 reset status", status_o, 8'h00);
    chk(irq_o == 1'b0 && mem_req_o == 1'b0 && xfer_hold_o == 1'b0, "R11 reset outputs",
        {irq_o, mem_req_o, xfer_hold_o}, 0);

    // direct mode, interrupt disabled
    put_desc(32'h100, 32'h1000_0000, 32'h3000_0100, 32'h2000_0000, 32'h0000_0011, 32'h0, 32'h40, 1);
    r0 = req_cnt;
    reg_wr(3'd0, 32'h100);
    reg_wr(3'd1, 32'h1);
    chk(status_o == 8'h01, "R4 busy after start", status_o, 8'h01);
    wait_idle();
    @(negedge clk);
    chk(status_o == 8'h02, "R2 direct done", status_o, 8'h02);
    chk(req_cnt - r0 == 3, "R2 three reads", req_cnt - r0, 3);
    chk(irq_o == 1'b0, "R9 irq disabled", irq_o, 0);
    reg_wr(3'd2, 32'h1);
    chk(irq_o == 1'b1, "R9 irq after enable", irq_o, 1);
    reg_wr(3'd4, 32'h1);
    chk(irq_o == 1'b0, "R9 irq cleared", irq_o, 0);

    // three-link chain, masked interrupt
    put_desc(32'h200, 32'hA000_0000, 32'h1, 32'hB000_0000, 32'h2, 32'h0000_0300, 32'h100, 1);
    put_desc(32'h300, 32'hA100_0000, 32'h3, 32'hB100_0000, 32'h4, 32'h0000_043E, 32'h200, 1);
    put_desc(32'h420, 32'hA200_0000, 32'h5, 32'hB200_0000, 32'h6, 32'h0000_0001, 32'h300, 1);
    reg_wr(3'd3, 32'h1);
    r0 = req_cnt; x0 = xs_cnt;
    reg_wr(3'd0, 32'h200);
    reg_wr(3'd1, 32'h1);
    wait_idle();
    @(negedge clk);
    chk(xs_cnt - x0 == 3, "R3 three transfers", xs_cnt - x0, 3);
    chk(req_cnt - r0 == 9, "R3 nine reads", req_cnt - r0, 9);
    chk(status_o == 8'h02, "R3 chain done", status_o, 8'h02);
    chk(irq_o == 1'b0, "R9 masked", irq_o, 0);
    reg_wr(3'd3, 32'h0);
    chk(irq_o == 1'b1, "R9 unmasked", irq_o, 1);
    reg_wr(3'd4, 32'h1);

    // start while busy
    put_desc(32'h500, 32'hC000_0000, 32'h7, 32'hD000_0000, 32'h8, 32'h0, 32'h10, 1);
    put_desc(32'h600, 32'hE000_0000, 32'h9, 32'hF000_0000, 32'hA, 32'h0, 32'h20, 0);
    eng_delay = 20; x0 = xs_cnt;
    reg_wr(3'd0, 32'h500);
    reg_wr(3'd1, 32'h1);
    wait_xs(x0 + 1);
    reg_wr(3'd0, 32'h600);
    reg_wr(3'd1, 32'h1);
    chk(status_o == 8'h01, "R5 still busy", status_o, 8'h01);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(xs_cnt - x0 == 1, "R5 one transfer", xs_cnt - x0, 1);

    // pause and resume mid-chain
    put_desc(32'h700, 32'h1100_0000, 32'hB, 32'h2200_0000, 32'hC, 32'h0000_0800, 32'h30, 1);
    put_desc(32'h800, 32'h1300_0000, 32'hD, 32'h2400_0000, 32'hE, 32'h0000_0001, 32'h40, 1);
    x0 = xs_cnt;
    reg_wr(3'd0, 32'h700);
    reg_wr(3'd1, 32'h1);
    wait_xs(x0 + 1);
    reg_wr(3'd1, 32'h2);
    chk(status_o == 8'h05, "R6 pause flag", status_o, 8'h05);
    r0 = req_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == r0 && xs_cnt == x0 + 1, "R6 frozen", req_cnt - r0, 0);
    chk(xfer_hold_o == 1'b1, "R6 hold", xfer_hold_o, 1);
    reg_wr(3'd1, 32'h4);
    wait_idle();
    @(negedge clk);
    chk(xs_cnt - x0 == 2, "R6 resumed chain", xs_cnt - x0, 2);
    chk(status_o == 8'h06, "R10 pause sticky with done", status_o, 8'h06);
    reg_wr(3'd4, 32'h1);

    // abort during transfer
    put_desc(32'h900, 32'h5500_0000, 32'hF, 32'h6600_0000, 32'h10, 32'h0, 32'h50, 1);
    eng_delay = 50; x0 = kill_cnt;
    reg_wr(3'd0, 32'h900);
    reg_wr(3'd1, 32'h1);
    chk(status_o == 8'h01, "R10 start clears flags", status_o, 8'h01);
    wait_xs(xs_cnt + 1);
    reg_wr(3'd1, 32'h8);
    chk(status_o == 8'h08, "R7 abort flag", status_o, 8'h08);
    repeat (60) @(negedge clk);
    chk(kill_cnt - x0 == 1, "R7 kill pulse", kill_cnt - x0, 1);
    chk(status_o == 8'h08 && irq_o, "R9 abort irq", {status_o, irq_o}, 9'h011);
    reg_wr(3'd4, 32'h1);

    // error stops chain
    put_desc(32'hA00, 32'h7700_0000, 32'h11, 32'h8800_0000, 32'h12, 32'h0000_0B00, 32'h60, 1);
    put_desc(32'hB00, 32'h9900_0000, 32'h13, 32'hAA00_0000, 32'h14, 32'h0000_0001, 32'h70, 0);
    eng_delay = 4; err_inject = 4'b0100; x0 = xs_cnt;
    reg_wr(3'd0, 32'hA00);
    reg_wr(3'd1, 32'h1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(status_o == 8'h40, "R8 target abort flag", status_o, 8'h40);
    chk(xs_cnt - x0 == 1, "R8 chain stopped", xs_cnt - x0, 1);
    chk(irq_o == 1'b1, "R9 error irq", irq_o, 1);

    chk(exp_q.size() == 0, "R1 all transfers seen", exp_q.size(), 0);
    chk(bad_addr == 0, "R1 read addresses", bad_addr, 0);
    finish_up();
  end
endmodule